// File: doc/BRIEF.md
# Serial Configuration Command Receiver

This block receives configuration commands over a three-wire serial link (serial clock, data in, frame enable) and returns register contents on a single data-out line. Every command opens with a 13-bit header. The header carries a chip identifier, a register address and an operation code. The block acts on a command only when the identifier matches the value strapped on its `chip_id` pins. Several identical chips can therefore share one serial link, and each one answers only the commands addressed to it.

Six addresses are decoded:

- a 2-bit shaping-time select;
- a 2-bit output-lane-count select;
- an 8-bit run-control register;
- a 128-bit per-channel kill mask;
- a 128-bit per-channel test-inject mask;
- a 2-bit reset-command port that issues one of three reset pulses.

A register can be written with a payload whose length matches its width, or read back serially. It can also be forced to all ones, forced to all zeros, or returned to its preset value by a single header with no payload. All register contents drive the rest of the chip through parallel outputs.

Top module: `scp_prog_if`

## Requirements
- R1: While `frame_en` is high, the first 13 bits clocked in on rising `clk` edges form the header, MSB first: chip id in bits 12..8, address in bits 7..4..3 order as addr[4:0] in bits 7..3, operation in bits 2..0. Any clock edge with `frame_en` low returns the bit position to the start of a header.
- R2: A command whose header id differs from `chip_id` changes no register, produces no reset pulse, and leaves `sdo` at 0.
- R3: Operation 1 (write) takes a payload that follows the header, MSB first. The payload is 2 bits for address 1 (shaping) and address 4 (lanes), 8 bits for address 5 (run control), and 128 bits for address 2 (kill) and address 3 (inject). The register updates on the edge that captures the last payload bit. Bits beyond the payload are ignored. A frame that ends before the payload is complete changes nothing.
- R4: Operation 2 (read) sends the addressed register MSB first on `sdo`. `sdo` changes on falling edges. The first bit appears on the falling edge after the last header bit. After the register width has been sent, `sdo` returns to 0.
- R5: Operation 3 sets every bit of the addressed register to 1.
- R6: Operation 4 clears every bit of the addressed register to 0.
- R7: Operation 5 loads the register's preset value. The presets are: shaping 2'b10, lanes 2'b01, run control 8'h04, and kill and inject all zeros.
- R8: Addresses 0 and 7 to 31, and operation codes 0, 6 and 7, change no register and produce no readback.
- R9: A write of code c to address 6 raises `rst_pulse[c-1]` for exactly one clock: code 1 gives bit 0, code 2 gives bit 1, code 3 gives bit 2. Code 0 gives no pulse. Operations 3, 4 and 5 on address 6 do nothing. A read of address 6 returns zeros.
- R10: A synchronous active-low `rst_n` loads every register preset, clears `rst_pulse`, and drives `sdo` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; data is captured on the rising edge, readback changes on the falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_en | input | 1 | High for the duration of one command; low realigns the header |
| sdi | input | 1 | Serial command and payload input |
| chip_id | input | 5 | Strapped chip identifier |
| sdo | output | 1 | Serial readback output, 0 when idle |
| shape_sel | output | 2 | Shaping-time select |
| lane_sel | output | 2 | Output-lane-count select |
| run_ctrl | output | 8 | Bit 0 send-data enable, bit 1 reject new hits, bit 2 capture crossing counter |
| kill_mask | output | 128 | Per-channel discriminator kill |
| inject_mask | output | 128 | Per-channel test-pulse enable |
| rst_pulse | output | 3 | One-clock pulses for the three reset kinds |

## Verification
On every cycle, the assertions check the following:

- a register holds its value on any cycle without a qualified strobe, and a foreign-id or unassigned header never disturbs any register;
- set, clear and default land on the edge after their strobe;
- `sdo` is 0 whenever no readback is in progress;
- reset pulses are single-cycle and one-hot.

Other behaviours can only be shown by the bench's scenarios, because the observation spans many cycles: the MSB-first bit order of writes and reads, payload lengths per address, truncated and overlong frames, realignment after a dropped frame, and the exact falling-edge timing of the readback stream.

// File: rtl/scp_pkg.sv
// Package: shared constants, header layout and per-address length table
// for the serial configuration receiver.
package scp_pkg;
    localparam int ID_W    = 5;
    localparam int ADDR_W  = 5;
    localparam int OP_W    = 3;
    localparam int HDR_W   = ID_W + ADDR_W + OP_W;
    localparam int MAX_LEN = 128;
    localparam int CNT_W   = 8;
    localparam int NREG    = 6;

    localparam logic [OP_W-1:0] OP_WRITE   = 3'd1;
    localparam logic [OP_W-1:0] OP_READ    = 3'd2;
    localparam logic [OP_W-1:0] OP_SET     = 3'd3;
    localparam logic [OP_W-1:0] OP_CLEAR   = 3'd4;
    localparam logic [OP_W-1:0] OP_DEFAULT = 3'd5;

    localparam logic [ADDR_W-1:0] A_SHAPE  = 5'd1;
    localparam logic [ADDR_W-1:0] A_KILL   = 5'd2;
    localparam logic [ADDR_W-1:0] A_INJ    = 5'd3;
    localparam logic [ADDR_W-1:0] A_LANES  = 5'd4;
    localparam logic [ADDR_W-1:0] A_CTRL   = 5'd5;
    localparam logic [ADDR_W-1:0] A_RSTCMD = 5'd6;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [ADDR_W-1:0] addr;
        logic [OP_W-1:0]   op;
    } hdr_t;

    // Payload length in bits for an address; 0 marks an unassigned address.
    function automatic logic [CNT_W-1:0] reg_len(input logic [ADDR_W-1:0] a);
        case (a)
            A_SHAPE, A_LANES, A_RSTCMD: reg_len = 8'd2;
            A_CTRL:                     reg_len = 8'd8;
            A_KILL, A_INJ:              reg_len = 8'd128;
            default:                    reg_len = 8'd0;
        endcase
    endfunction
endpackage

// File: rtl/scp_frame_rx.sv
// Module: scp_frame_rx
// Counts bits within a frame, shifts in the 13-bit header and then the
// payload, and flags the edge that completes the header and the edge that
// completes the payload of the addressed register.
// Assumes: frame_en is low between commands for at least one clock edge.
module scp_frame_rx
    import scp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_en,
    input  logic               sdi,
    output hdr_t               hdr,
    output hdr_t               hdr_next,
    output logic               hdr_stb,
    output logic [MAX_LEN-1:0] pay_next,
    output logic               pay_stb
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] HDR_CNT  = CNT_W'(HDR_W);
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);

    logic [CNT_W-1:0]   cnt;
    logic [HDR_W-1:0]   hdr_sr;
    logic [MAX_LEN-1:0] pay_sr;
    logic [CNT_W-1:0]   len;
    logic [CNT_W-1:0]   pay_last;

    // Bit position within the frame, saturating, cleared outside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_en) cnt <= '0;
        else if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // Header shift register, frozen once 13 bits are in.
    always_ff @(posedge clk) begin
        if (!rst_n) hdr_sr <= '0;
        else if (frame_en && cnt < HDR_CNT) hdr_sr <= {hdr_sr[HDR_W-2:0], sdi};
    end

    // Payload shift register, fed by every bit after the header.
    always_ff @(posedge clk) begin
        if (!rst_n) pay_sr <= '0;
        else if (frame_en && cnt >= HDR_CNT) pay_sr <= {pay_sr[MAX_LEN-2:0], sdi};
    end

    // Strobes and the values the current edge is about to capture.
    always_comb begin
        hdr      = hdr_t'(hdr_sr);
        hdr_next = hdr_t'({hdr_sr[HDR_W-2:0], sdi});
        hdr_stb  = frame_en && (cnt == HDR_LAST);
        pay_next = {pay_sr[MAX_LEN-2:0], sdi};
        len      = reg_len(hdr.addr);
        pay_last = HDR_CNT + len - 1'b1;
        pay_stb  = frame_en && (len != '0) && (cnt >= HDR_CNT) && (cnt == pay_last);
    end

    a_r1_cnt_realign: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_en |=> cnt == '0);
    a_r1_hdr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_en && cnt >= HDR_CNT) |=> $stable(hdr_sr));
endmodule

// File: rtl/scp_cfg_reg.sv
// Module: scp_cfg_reg
// One configuration register of parameterised width with write, set-all,
// clear-all and load-preset controls. Reset loads the preset.
// Assumes: at most one control is active in a cycle.
module scp_cfg_reg #(
    parameter int           W   = 8,
    parameter logic [W-1:0] DEF = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic         def_en,
    output logic [W-1:0] q
);
    // Register update by priority of the control strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || def_en) q <= DEF;
        else if (wr_en)       q <= wr_data;
        else if (set_en)      q <= '1;
        else if (clr_en)      q <= '0;
    end

    a_r3_single_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, set_en, clr_en, def_en}));
    a_r5_set_ones: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> q == '1);
    a_r6_clear_zeros: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |=> q == '0);
    a_r7_preset: assert property (@(posedge clk) disable iff (!rst_n)
        def_en |=> q == DEF);
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en || set_en || clr_en || def_en) |=> $stable(q));
endmodule

// File: rtl/scp_readback.sv
// Module: scp_readback
// Loads a left-aligned register image on the header edge of a read, then
// shifts it out MSB first; sdo is updated on falling clock edges and is 0
// whenever no bits remain.
// Assumes: load_len is at most MAX_LEN.
module scp_readback
    import scp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_en,
    input  logic               load,
    input  logic [MAX_LEN-1:0] load_word,
    input  logic [CNT_W-1:0]   load_len,
    output logic               sdo
);
    logic [MAX_LEN-1:0] sr;
    logic [CNT_W-1:0]   left;

    // Readback shift register and remaining-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_en) begin
            left <= '0;
        end else if (load) begin
            sr   <= load_word;
            left <= load_len;
        end else if (left != '0) begin
            sr   <= sr << 1;
            left <= left - 1'b1;
        end
    end

    // Output bit launched on the falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) sdo <= 1'b0;
        else        sdo <= (left != '0) ? sr[MAX_LEN-1] : 1'b0;
    end

    a_r4_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (left == '0) |-> sdo == 1'b0);
    a_r4_nonempty_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> load_len != '0);
endmodule

// File: rtl/scp_prog_if.sv
// Module: scp_prog_if (top)
// Serial configuration receiver: matches the header id against the strap,
// decodes address and operation, drives the register strobes, the readback
// path and the reset-command pulses.
// Assumes: chip_id is static; clk is the serial clock.
module scp_prog_if
    import scp_pkg::*;
#(
    parameter logic [1:0]         SHAPE_DEF = 2'b10,
    parameter logic [1:0]         LANES_DEF = 2'b01,
    parameter logic [7:0]         CTRL_DEF  = 8'h04,
    parameter logic [MAX_LEN-1:0] KILL_DEF  = '0,
    parameter logic [MAX_LEN-1:0] INJ_DEF   = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_en,
    input  logic               sdi,
    input  logic [ID_W-1:0]    chip_id,
    output logic               sdo,
    output logic [1:0]         shape_sel,
    output logic [1:0]         lane_sel,
    output logic [7:0]         run_ctrl,
    output logic [MAX_LEN-1:0] kill_mask,
    output logic [MAX_LEN-1:0] inject_mask,
    output logic [2:0]         rst_pulse
);
    hdr_t               hdr, hdr_next;
    logic               hdr_stb, pay_stb;
    logic [MAX_LEN-1:0] pay_next;
    logic               hdr_ok, wr_hit, rd_load;
    logic [NREG-1:0]    wr_sel, set_sel, clr_sel, def_sel;
    logic [MAX_LEN-1:0] rd_word;

    scp_frame_rx u_rx (
        .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .sdi(sdi),
        .hdr(hdr), .hdr_next(hdr_next), .hdr_stb(hdr_stb),
        .pay_next(pay_next), .pay_stb(pay_stb)
    );

    // Per-address strobes; index i serves address i+1.
    always_comb begin
        hdr_ok = hdr_stb && (hdr_next.id == chip_id);
        wr_hit = pay_stb && (hdr.id == chip_id) && (hdr.op == OP_WRITE);
        for (int i = 0; i < NREG; i++) begin
            wr_sel[i]  = wr_hit && (hdr.addr == ADDR_W'(i + 1));
            set_sel[i] = hdr_ok && (hdr_next.op == OP_SET)
                         && (hdr_next.addr == ADDR_W'(i + 1)) && (ADDR_W'(i + 1) != A_RSTCMD);
            clr_sel[i] = hdr_ok && (hdr_next.op == OP_CLEAR)
                         && (hdr_next.addr == ADDR_W'(i + 1)) && (ADDR_W'(i + 1) != A_RSTCMD);
            def_sel[i] = hdr_ok && (hdr_next.op == OP_DEFAULT)
                         && (hdr_next.addr == ADDR_W'(i + 1)) && (ADDR_W'(i + 1) != A_RSTCMD);
        end
        rd_load = hdr_ok && (hdr_next.op == OP_READ) && (reg_len(hdr_next.addr) != '0);
    end

    scp_cfg_reg #(.W(2), .DEF(SHAPE_DEF)) u_shape (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[0]), .wr_data(pay_next[1:0]),
        .set_en(set_sel[0]), .clr_en(clr_sel[0]), .def_en(def_sel[0]), .q(shape_sel)
    );
    scp_cfg_reg #(.W(MAX_LEN), .DEF(KILL_DEF)) u_kill (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[1]), .wr_data(pay_next),
        .set_en(set_sel[1]), .clr_en(clr_sel[1]), .def_en(def_sel[1]), .q(kill_mask)
    );
    scp_cfg_reg #(.W(MAX_LEN), .DEF(INJ_DEF)) u_inject (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[2]), .wr_data(pay_next),
        .set_en(set_sel[2]), .clr_en(clr_sel[2]), .def_en(def_sel[2]), .q(inject_mask)
    );
    scp_cfg_reg #(.W(2), .DEF(LANES_DEF)) u_lanes (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[3]), .wr_data(pay_next[1:0]),
        .set_en(set_sel[3]), .clr_en(clr_sel[3]), .def_en(def_sel[3]), .q(lane_sel)
    );
    scp_cfg_reg #(.W(8), .DEF(CTRL_DEF)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[4]), .wr_data(pay_next[7:0]),
        .set_en(set_sel[4]), .clr_en(clr_sel[4]), .def_en(def_sel[4]), .q(run_ctrl)
    );

    // Left-aligned image of the register named by the incoming header.
    always_comb begin
        case (hdr_next.addr)
            A_SHAPE: rd_word = {shape_sel, {(MAX_LEN-2){1'b0}}};
            A_LANES: rd_word = {lane_sel,  {(MAX_LEN-2){1'b0}}};
            A_CTRL:  rd_word = {run_ctrl,  {(MAX_LEN-8){1'b0}}};
            A_KILL:  rd_word = kill_mask;
            A_INJ:   rd_word = inject_mask;
            default: rd_word = '0;
        endcase
    end

    scp_readback u_rb (
        .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .load(rd_load),
        .load_word(rd_word), .load_len(reg_len(hdr_next.addr)), .sdo(sdo)
    );

    // Reset-command pulses, one clock long, decoded from the 2-bit code.
    always_ff @(posedge clk) begin
        if (!rst_n || !wr_sel[5]) begin
            rst_pulse <= '0;
        end else begin
            case (pay_next[1:0])
                2'd1:    rst_pulse <= 3'b001;
                2'd2:    rst_pulse <= 3'b010;
                2'd3:    rst_pulse <= 3'b100;
                default: rst_pulse <= 3'b000;
            endcase
        end
    end

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_pulse != '0) |=> rst_pulse == '0);
    a_r9_pulse_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rst_pulse));
    a_r2_foreign_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_stb && hdr_next.id != chip_id) |=>
            ($stable(shape_sel) && $stable(lane_sel) && $stable(run_ctrl)
             && $stable(kill_mask) && $stable(inject_mask)));
    a_r8_unassigned_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_stb && (reg_len(hdr_next.addr) == '0 || hdr_next.op == 3'd0 || hdr_next.op > OP_DEFAULT)) |=>
            ($stable(shape_sel) && $stable(lane_sel) && $stable(run_ctrl)
             && $stable(kill_mask) && $stable(inject_mask)));
endmodule

// File: tb/scp_prog_if_bench.sv
module scp_prog_if_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] MY_ID = 5'h13;
    localparam logic [4:0] OTHER_ID = 5'h0C;
    localparam logic [127:0] KPAT = 128'hF0E1_D2C3_B4A5_9687_7869_5A4B_3C2D_1E0F;
    // {addr, op, data, expected register value}
    localparam int NV = 14;
    localparam logic [23:0] VEC [NV] = '{
        {5'd1, 3'd1, 8'h03, 8'h03}, {5'd1, 3'd4, 8'h00, 8'h00},
        {5'd1, 3'd5, 8'h00, 8'h02}, {5'd1, 3'd3, 8'h00, 8'h03},
        {5'd4, 3'd1, 8'h02, 8'h02}, {5'd4, 3'd5, 8'h00, 8'h01},
        {5'd5, 3'd1, 8'hA5, 8'hA5}, {5'd5, 3'd4, 8'h00, 8'h00},
        {5'd5, 3'd3, 8'h00, 8'hFF}, {5'd5, 3'd5, 8'h00, 8'h04},
        {5'd5, 3'd0, 8'h00, 8'h04}, {5'd5, 3'd6, 8'h00, 8'h04},
        {5'd1, 3'd7, 8'h00, 8'h03}, {5'd4, 3'd1, 8'h03, 8'h03}
    };

    logic clk = 1'b0, rst_n = 1'b0, frame_en = 1'b0, sdi = 1'b0;
    logic sdo;
    logic [1:0] shape_sel, lane_sel;
    logic [7:0] run_ctrl;
    logic [127:0] kill_mask, inject_mask;
    logic [2:0] rst_pulse;
    int n_checks = 0, n_bad = 0;

    scp_prog_if u_scp_prog_if (
        .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .sdi(sdi), .chip_id(MY_ID),
        .sdo(sdo), .shape_sel(shape_sel), .lane_sel(lane_sel), .run_ctrl(run_ctrl),
        .kill_mask(kill_mask), .inject_mask(inject_mask), .rst_pulse(rst_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input logic [127:0] got, input logic [127:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        sdi = b;
        @(negedge clk);
    endtask

    // Drives header then nbits of payload; returns just after the falling edge
    // that follows the edge capturing the last bit, frame still open.
    task automatic send_cmd(input logic [4:0] id, input logic [4:0] addr, input logic [2:0] op,
                            input logic [127:0] pay, input int nbits);
        logic [12:0] h;
        h = {id, addr, op};
        frame_en = 1'b1;
        for (int i = 12; i >= 0; i--) shift_bit(h[i]);
        for (int i = nbits - 1; i >= 0; i--) shift_bit(pay[i]);
        #1;
    endtask

    task automatic end_frame();
        frame_en = 1'b0;
        sdi = 1'b0;
        @(negedge clk);
        #1;
    endtask

    // Read: collect len bits from sdo, then check the line falls back to 0.
    task automatic read_reg(input logic [4:0] id, input logic [4:0] addr, input int len,
                            output logic [127:0] got, output logic tail);
        got = '0;
        send_cmd(id, addr, 3'd2, '0, 0);
        for (int i = len - 1; i >= 0; i--) begin
            got[i] = sdo;
            shift_bit(1'b0);
            #1;
        end
        tail = sdo;
        end_frame();
    endtask

    function automatic logic [7:0] small_reg(input logic [4:0] a);
        case (a)
            5'd1:    small_reg = {6'd0, shape_sel};
            5'd4:    small_reg = {6'd0, lane_sel};
            default: small_reg = run_ctrl;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] op);
        case (op)
            3'd1: req_of = "R3";
            3'd3: req_of = "R5";
            3'd4: req_of = "R6";
            3'd5: req_of = "R7";
            default: req_of = "R8";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] got;
        logic tail;
        logic [7:0] a_shape, a_lanes, a_ctrl;
        repeat (3) @(negedge clk);
        #1;
        // R10: reset state
        check("R10", "shape preset", 128'(shape_sel), 128'h2);
        check("R10", "lanes preset", 128'(lane_sel), 128'h1);
        check("R10", "ctrl preset", 128'(run_ctrl), 128'h04);
        check("R10", "kill preset", kill_mask, '0);
        check("R10", "inject preset", inject_mask, '0);
        check("R10", "sdo idle", 128'(sdo), 128'h0);
        check("R10", "pulse idle", 128'(rst_pulse), 128'h0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;

        // Vector table over the small registers (R3, R5, R6, R7, R8)
        for (int v = 0; v < NV; v++) begin
            logic [4:0] addr;
            logic [2:0] op;
            addr = VEC[v][23:19];
            op   = VEC[v][18:16];
            send_cmd(MY_ID, addr, op, 128'(VEC[v][15:8]),
                     (op == 3'd1) ? ((addr == 5'd5) ? 8 : 2) : 0);
            check(req_of(op), $sformatf("vector %0d", v), 128'(small_reg(addr)), 128'(VEC[v][7:0]));
            end_frame();
        end

        // R3: 128-bit write
        send_cmd(MY_ID, 5'd2, 3'd1, KPAT, 128);
        check("R3", "kill write", kill_mask, KPAT);
        end_frame();
        // R4: read kill and run control
        read_reg(MY_ID, 5'd2, 128, got, tail);
        check("R4", "kill readback", got, KPAT);
        check("R4", "sdo after kill read", 128'(tail), 128'h0);
        read_reg(MY_ID, 5'd5, 8, got, tail);
        check("R4", "ctrl readback", got, 128'h04);
        check("R4", "sdo after ctrl read", 128'(tail), 128'h0);

        // R2: foreign id write and read
        send_cmd(OTHER_ID, 5'd2, 3'd1, '0, 128);
        check("R2", "kill after foreign write", kill_mask, KPAT);
        end_frame();
        read_reg(OTHER_ID, 5'd2, 8, got, tail);
        check("R2", "sdo during foreign read", got, '0);
        send_cmd(OTHER_ID, 5'd5, 3'd4, '0, 0);
        check("R2", "ctrl after foreign clear", 128'(run_ctrl), 128'h04);
        end_frame();

        // R8: unassigned addresses
        a_shape = {6'd0, shape_sel};
        a_lanes = {6'd0, lane_sel};
        a_ctrl = run_ctrl;
        send_cmd(MY_ID, 5'd9, 3'd1, 128'hFF, 8);
        end_frame();
        send_cmd(MY_ID, 5'd0, 3'd3, '0, 0);
        end_frame();
        check("R8", "shape after unassigned", 128'(shape_sel), 128'(a_shape));
        check("R8", "lanes after unassigned", 128'(lane_sel), 128'(a_lanes));
        check("R8", "ctrl after unassigned", 128'(run_ctrl), 128'(a_ctrl));
        check("R8", "kill after unassigned", kill_mask, KPAT);
        check("R8", "inject after unassigned", inject_mask, '0);
        read_reg(MY_ID, 5'd9, 8, got, tail);
        check("R8", "sdo on unassigned read", got, '0);

        // R3: truncated payload; R1: realignment after a dropped frame
        send_cmd(MY_ID, 5'd5, 3'd1, 128'h1F, 5);
        end_frame();
        check("R3", "ctrl after truncated write", 128'(run_ctrl), 128'h04);
        send_cmd(MY_ID, 5'd5, 3'd1, 128'h35, 8);
        check("R1", "ctrl msb-first after realign", 128'(run_ctrl), 128'h35);
        end_frame();
        // R3: overlong payload, extra bits ignored
        send_cmd(MY_ID, 5'd1, 3'd1, 128'h0E, 5);
        check("R3", "shape with extra bits", 128'(shape_sel), 128'h1);
        end_frame();

        // R9: reset-command pulses
        send_cmd(MY_ID, 5'd6, 3'd1, 128'h2, 2);
        check("R9", "pulse code 2", 128'(rst_pulse), 128'h2);
        end_frame();
        check("R9", "pulse ends", 128'(rst_pulse), 128'h0);
        send_cmd(MY_ID, 5'd6, 3'd1, 128'h3, 2);
        check("R9", "pulse code 3", 128'(rst_pulse), 128'h4);
        end_frame();
        send_cmd(MY_ID, 5'd6, 3'd1, 128'h1, 2);
        check("R9", "pulse code 1", 128'(rst_pulse), 128'h1);
        end_frame();
        send_cmd(MY_ID, 5'd6, 3'd1, 128'h0, 2);
        check("R9", "pulse code 0", 128'(rst_pulse), 128'h0);
        end_frame();
        send_cmd(MY_ID, 5'd6, 3'd3, '0, 0);
        check("R9", "set on reset port", 128'(rst_pulse), 128'h0);
        end_frame();

        // R5, R6, R7 on the wide registers
        send_cmd(MY_ID, 5'd3, 3'd3, '0, 0);
        check("R5", "inject set", inject_mask, '1);
        end_frame();
        send_cmd(MY_ID, 5'd3, 3'd5, '0, 0);
        check("R7", "inject preset", inject_mask, '0);
        end_frame();
        send_cmd(MY_ID, 5'd2, 3'd4, '0, 0);
        check("R6", "kill clear", kill_mask, '0);
        end_frame();

        // R10: reset in the middle of a readback
        send_cmd(MY_ID, 5'd5, 3'd3, '0, 0);
        end_frame();
        send_cmd(MY_ID, 5'd5, 3'd2, '0, 0);
        check("R4", "first readback bit", 128'(sdo), 128'h1);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R10", "ctrl after reset", 128'(run_ctrl), 128'h04);
        check("R10", "sdo after reset", 128'(sdo), 128'h0);
        check("R10", "shape after reset", 128'(shape_sel), 128'h2);
        rst_n = 1'b1;
        end_frame();

        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule